// File: doc/BRIEF.md
# Dual Reload Timer Pair with Toggle Outputs

This block holds two 16-bit down counters, timer A and timer B, each with its own reload register. A running timer steps down by one on each of its clock ticks. When it is at zero and takes a tick, it reloads from its register and gives a single-cycle underflow pulse. Software starts and stops each timer on its own, and it can read and write both counters and both reload registers through one small register port.

Each timer gets its ticks from one of two sources. The first is the system clock divided by a power of two. The second is an external pin, which is synchronized and counted on its rising edges. Timer B can instead take its ticks from timer A's underflow, so the two timers act as one 32-bit counter.

Four synchronous outputs are tied to timer B. Each one either follows a software-driven bit or toggles on every underflow of timer B.

Top module: `tmr_pair_top`

## Requirements
- R1: After the asynchronous reset, both counters and both reload registers read 0, `out_o` is 0 and `uflow_o` is 0.
- R2: A running timer decrements by exactly one on each tick while its value is non-zero.
- R3: A running timer at 0 that takes a tick loads its reload register at that edge. Its `uflow_o` bit is high for that one cycle (bit 0 is timer A, bit 1 is timer B).
- R4: A timer whose `run_i` bit is 0 holds its value, whatever its tick source does.
- R5: With `ext_src_i` bit 0 (internal source), a timer ticks once every 2^d system clocks, where d is its 3-bit divide field (`div_a_i` or `div_b_i`). The time between underflows is therefore (reload+1)*2^d cycles.
- R6: With `ext_src_i` bit 1 (external source), the pin is passed through a two-stage synchronizer. The timer steps once per rising edge of the pin, and a level held high gives only one step.
- R7: With `cascade_i` high, timer B steps only in cycles where timer A underflows, so the pair counts as one 32-bit value.
- R8: An output whose `out_mode_i` bit is 0 takes the matching `out_val_i` bit at each clock edge.
- R9: An output whose `out_mode_i` bit is 1 inverts at each underflow of timer B and otherwise holds its value.
- R10: The register port uses address 0 for the timer A count, 1 for the timer A reload, 2 for the timer B count and 3 for the timer B reload. `rd_data_o` shows the addressed register combinationally. A write with `wr_en_i` lands at the next edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 2 | Run enable per timer (bit 0 is A) |
| ext_src_i | input | 2 | Tick source per timer: 1 selects the external pin |
| div_a_i | input | 3 | Divide exponent for timer A |
| div_b_i | input | 3 | Divide exponent for timer B |
| ext_a_i | input | 1 | External tick pin for timer A |
| ext_b_i | input | 1 | External tick pin for timer B |
| cascade_i | input | 1 | Timer B takes its ticks from timer A's underflow |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both read and write |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data of the addressed register |
| out_mode_i | input | 4 | Per output: 1 toggles on B underflow, 0 follows out_val_i |
| out_val_i | input | 4 | Software values for outputs in plain mode |
| out_o | output | 4 | Synchronous outputs |
| uflow_o | output | 2 | Underflow pulses (bit 0 is A, bit 1 is B) |

## Verification
The hardest state to reach is a cascaded underflow seen from timer B. It needs timer A to wrap many times, and timer B's value at any moment depends on the exact count of A's reloads. The bench gives timer A a short reload period and lets the pair run for a fixed number of cycles. It then checks that timer B has dropped by exactly the number of A wraps, with no B underflow along the way. Toggle mode is reached the same way: timer B is preloaded to 1 with a reload of 1, so each B underflow comes at a known edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_W = 16;
  localparam int DIV_W = 3;
  localparam int PRE_W = (1 << DIV_W) - 1;
  localparam int N_OUT = 4;

  typedef enum logic [1:0] {
    ADDR_CNT_A = 2'd0,
    ADDR_RLD_A = 2'd1,
    ADDR_CNT_B = 2'd2,
    ADDR_RLD_B = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic [2:0]       sync_q;
  logic             ext_rise;
  logic             div_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_i};
    end
  end

  // low d bits all ones: one tick every 2^d cycles
  always_comb begin
    mask = '0;
    for (int k = 0; k < PRE_W; k++) mask[k] = (k < int'(div_i));
  end

  assign div_tick = ((pre_q & mask) == mask);
  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign tick_o   = ext_sel_i ? ext_rise : div_tick;

  assert_ext_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_rld_i,
  input  logic [TMR_W-1:0] wr_data_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic [TMR_W-1:0] rld_o,
  output logic             uflow_o
);
  logic [TMR_W-1:0] cnt_q, rld_q;
  logic             step;

  assign step    = run_i & tick_i & ~wr_cnt_i;
  assign uflow_o = step & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (wr_rld_i) rld_q <= wr_data_i;
      if (wr_cnt_i)      cnt_q <= wr_data_i;
      else if (uflow_o)  cnt_q <= rld_q;
      else if (step)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !wr_cnt_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |=> cnt_q == $past(rld_q));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt_i) |=> $stable(cnt_q));
  assert_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_q == $past(wr_data_i));
endmodule

// File: rtl/tmr_sync_out.sv
module tmr_sync_out
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uflow_i,
  input  logic [N_OUT-1:0] mode_i,
  input  logic [N_OUT-1:0] val_i,
  output logic [N_OUT-1:0] out_o
);
  logic [N_OUT-1:0] out_q;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           out_q[i] <= 1'b0;
      else if (!mode_i[i])   out_q[i] <= val_i[i];
      else if (uflow_i)      out_q[i] <= ~out_q[i];
    end

    assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] && uflow_i) |=> out_q[i] != $past(out_q[i]));
    assert_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] && !uflow_i) |=> $stable(out_q[i]));
  end

  assign out_o = out_q;
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       run_i,
  input  logic [1:0]       ext_src_i,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [DIV_W-1:0] div_b_i,
  input  logic             ext_a_i,
  input  logic             ext_b_i,
  input  logic             cascade_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [TMR_W-1:0] wr_data_i,
  output logic [TMR_W-1:0] rd_data_o,
  input  logic [N_OUT-1:0] out_mode_i,
  input  logic [N_OUT-1:0] out_val_i,
  output logic [N_OUT-1:0] out_o,
  output logic [1:0]       uflow_o
);
  logic [1:0]       src_tick;
  logic [DIV_W-1:0] div_sel [2];
  logic [1:0]       ext_pin;
  logic             tick_b, uflow_a, uflow_b;
  logic [TMR_W-1:0] cnt_a, rld_a, cnt_b, rld_b;
  tmr_addr_e        addr;

  assign div_sel[0] = div_a_i;
  assign div_sel[1] = div_b_i;
  assign ext_pin    = {ext_b_i, ext_a_i};
  assign addr       = tmr_addr_e'(addr_i);

  for (genvar t = 0; t < 2; t++) begin : g_tick
    tmr_tick_gen u_tick (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ext_sel_i(ext_src_i[t]),
      .div_i    (div_sel[t]),
      .ext_i    (ext_pin[t]),
      .tick_o   (src_tick[t])
    );
  end

  tmr_counter u_tmr_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i[0]),
    .tick_i   (src_tick[0]),
    .wr_cnt_i (wr_en_i && addr == ADDR_CNT_A),
    .wr_rld_i (wr_en_i && addr == ADDR_RLD_A),
    .wr_data_i(wr_data_i),
    .cnt_o    (cnt_a),
    .rld_o    (rld_a),
    .uflow_o  (uflow_a)
  );

  assign tick_b = cascade_i ? uflow_a : src_tick[1];

  tmr_counter u_tmr_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i[1]),
    .tick_i   (tick_b),
    .wr_cnt_i (wr_en_i && addr == ADDR_CNT_B),
    .wr_rld_i (wr_en_i && addr == ADDR_RLD_B),
    .wr_data_i(wr_data_i),
    .cnt_o    (cnt_b),
    .rld_o    (rld_b),
    .uflow_o  (uflow_b)
  );

  tmr_sync_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .uflow_i(uflow_b),
    .mode_i (out_mode_i),
    .val_i  (out_val_i),
    .out_o  (out_o)
  );

  always_comb begin
    unique case (addr)
      ADDR_CNT_A: rd_data_o = cnt_a;
      ADDR_RLD_A: rd_data_o = rld_a;
      ADDR_CNT_B: rd_data_o = cnt_b;
      default:    rd_data_o = rld_b;
    endcase
  end

  assign uflow_o = {uflow_b, uflow_a};

  assert_cascade_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cascade_i && !uflow_a && !(wr_en_i && addr == ADDR_CNT_B)) |=> $stable(cnt_b));
  assert_uflow_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_b |=> !uflow_b || rld_b == '0);
endmodule

// File: tb/tmr_pair_top_test.sv
module tmr_pair_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  run = '0, ext_src = '0;
  logic [2:0]  div_a = '0, div_b = '0;
  logic        ext_a = 1'b0, ext_b = 1'b0, cascade = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [3:0]  out_mode = '0, out_val = '0, outs;
  logic [1:0]  uflow;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  tmr_pair_top uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .ext_src_i(ext_src),
    .div_a_i(div_a), .div_b_i(div_b), .ext_a_i(ext_a), .ext_b_i(ext_b),
    .cascade_i(cascade), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .out_mode_i(out_mode), .out_val_i(out_val),
    .out_o(outs), .uflow_o(uflow)
  );

  // reload, divide exponent, expected cycles between A underflows (R5)
  localparam int VEC [6][3] = '{
    '{3, 0, 4}, '{5, 1, 12}, '{2, 2, 12}, '{0, 3, 8}, '{7, 0, 8}, '{1, 7, 256}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rd_data);
  endtask

  task automatic period_a(output int n);
    while (!uflow[0]) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!uflow[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R1 reg", v, 0); end
    check("R1 out", int'(outs), 0);
    check("R1 uflow", int'(uflow), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 write/read each address
    for (int a = 0; a < 4; a++) wr(2'(a), 16'(100 + a));
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R10 rdwr", v, 100 + a); end

    // R5 vector table walk
    for (int i = 0; i < 6; i++) begin
      run = '0; ext_src = '0; div_a = 3'(VEC[i][1]);
      wr(2'd0, 16'(VEC[i][0]));
      wr(2'd1, 16'(VEC[i][0]));
      run[0] = 1'b1;
      period_a(v);
      check("R5 period", v, VEC[i][2]);
    end
    run = '0;
    @(negedge clk);

    // R2 decrement, R4 hold
    div_a = '0;
    wr(2'd0, 16'd10);
    wr(2'd2, 16'd40);
    run[0] = 1'b1;
    repeat (5) @(negedge clk);
    run[0] = 1'b0;
    rd(2'd0, v); check("R2 step", v, 5);
    rd(2'd2, v); check("R4 B stopped", v, 40);
    repeat (10) @(negedge clk);
    rd(2'd0, v); check("R4 hold", v, 5);

    // R3 underflow reload and pulse
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd9);
    run[0] = 1'b1; #1;
    check("R3 pulse", int'(uflow[0]), 1);
    @(negedge clk);
    run[0] = 1'b0;
    rd(2'd0, v); check("R3 reload", v, 9);
    check("R3 pulse end", int'(uflow[0]), 0);

    // R10 write wins over counting
    run[0] = 1'b1;
    wr(2'd0, 16'd77);
    run[0] = 1'b0;
    rd(2'd0, v); check("R10 priority", v, 77);

    // R6 external pin
    ext_src[0] = 1'b1;
    wr(2'd0, 16'd20);
    run[0] = 1'b1;
    for (int p = 0; p < 3; p++) begin
      ext_a = 1'b1; repeat (3) @(negedge clk);
      ext_a = 1'b0; repeat (3) @(negedge clk);
    end
    rd(2'd0, v); check("R6 edges", v, 17);
    ext_a = 1'b1; repeat (12) @(negedge clk);
    rd(2'd0, v); check("R6 level once", v, 16);
    run = '0; ext_a = 1'b0; ext_src = '0;
    repeat (4) @(negedge clk);

    // R7 cascade
    cascade = 1'b1;
    wr(2'd0, 16'd2); wr(2'd1, 16'd2);
    wr(2'd2, 16'd5); wr(2'd3, 16'd5);
    run = 2'b11;
    v = 0;
    for (int c = 0; c < 12; c++) begin v += int'(uflow[1]); @(negedge clk); end
    run = '0;
    check("R7 no B uflow", v, 0);
    rd(2'd2, v); check("R7 B count", v, 1);
    rd(2'd0, v); check("R7 A count", v, 2);
    cascade = 1'b0;

    // R8 plain outputs
    out_mode = '0; out_val = 4'b1010;
    @(negedge clk);
    check("R8 plain", int'(outs), 4'b1010);
    out_val = 4'b0000;
    @(negedge clk);
    check("R8 plain0", int'(outs), 0);

    // R9 toggle outputs on B underflow
    out_val = 4'b1100; out_mode = 4'b0011;
    wr(2'd2, 16'd1); wr(2'd3, 16'd1);
    check("R9 no toggle stopped", int'(outs), 4'b1100);
    run = 2'b10;
    repeat (2) @(negedge clk);
    run = '0;
    check("R9 toggle1", int'(outs), 4'b1111);
    run = 2'b10;
    repeat (2) @(negedge clk);
    run = '0;
    check("R9 toggle2", int'(outs), 4'b1100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule